// File: doc/BRIEF.md
# Grouped Wavefront Issue Scheduler

This block picks which pending wavefront instructions leave the instruction buffer of a compute unit. The wavefront slots are split into SIMD groups (four groups of ten by default). A rotor hands the issue slot to one group per clock in a fixed cycle, so each group is served once every four clocks. A vector operation keeps its SIMD busy for those four clocks, so a group never takes a second vector issue before its next turn.

In its slot, the active group can send one instruction to each of four execution ports: vector, scalar, shared-memory and global-memory. Each wavefront holds one instruction, so the instructions issued together always come from different wavefronts. Within a class, the wavefront that has waited longest wins, and a tie goes to the lowest slot index. Internal markers (wait, no-op, barrier) never reach a port. They are dropped from the buffer one cycle after they arrive, whatever the rotation and readiness.

Upstream logic loads a slot with an instruction class code and raises a per-slot dependency-ready flag. Each port reports back a busy flag. The scheduler returns a registered strobe per port carrying the group and the wavefront index.

Top module: `isu_sched`

## Requirements
- R1: After reset, the group offered the slot in the n-th clock (n = 0, 1, 2, ...) is n mod 4. Every issue reports that group in its group field.
- R2: A port issues in a slot only from a wavefront of the active group that is pending, has its ready flag set and holds that port's class code. Class codes are 0 vector, 1 scalar, 2 shared-memory and 3 global-memory. Each port issues at most one instruction per slot.
- R3: All four ports may issue in the same slot. Instructions issued together always carry different wavefront indices.
- R4: Within a class, the candidate with the largest wait count wins, and a tie goes to the lowest wavefront index. The wait count is 0 on the clock after loading, rises by one each later clock while the slot is pending, and stops at 15.
- R5: A port whose busy input is high in a slot issues nothing in that slot. The candidate stays pending and keeps ageing.
- R6: Class codes 4 to 7 are internal markers. They leave the slot one clock after loading, issue on no port, and the slot accepts a new load on the following clock.
- R7: A load into a slot that is already pending is ignored, even if that slot issues in the same clock.
- R8: Issue outputs appear on the clock after the slot, stay high for one clock, and drive zero in the index fields when the valid bit is low.
- R9: While reset is held, the outputs are zero, the rotation returns to group 0 and every slot becomes empty. Loads during reset are dropped.
- R10: A slot with no eligible wavefront issues nothing, and the rotation still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 40 | Per-slot load strobe (slot = group*10 + wave) |
| ld_type | input | 120 | Per-slot 3-bit class code, slot i at bits [3i+2:3i] |
| dep_rdy | input | 40 | Per-slot dependency-ready flag |
| port_busy | input | 4 | Busy flag per port: bit 0 vector, 1 scalar, 2 shared-memory, 3 global-memory |
| iss_vld | output | 4 | Issue strobe per port |
| iss_wave | output | 16 | 4-bit wavefront index per port, port p at [4p+3:4p] |
| iss_grp | output | 8 | 2-bit group index per port, port p at [2p+1:2p] |

## Verification
Assertions check four rules on every clock: the group field follows the rotation, each issue came from a wavefront that was ready, a busy port stays silent, and co-issued instructions name different wavefronts. Idle outputs are also checked to be zero. Only the bench's reference model can show whether the right wavefront won: oldest-first with ties to the lowest index, a candidate held across a busy port, internal markers dropped, and loads into a pending slot ignored. It also shows whether an eligible instruction was left unissued. The directed scenarios cover quad issue, a blocked vector port, ageing order and reloading after a marker. A long random run then mixes all of these.

// File: rtl/isu_pkg.sv
package isu_pkg;
   localparam int NCLS = 4;  // execution ports: vector, scalar, shared-mem, global-mem
   localparam int TW   = 3;  // class code width

   // codes 4..7 never leave through a port
   function automatic logic is_internal(input logic [TW-1:0] code);
      return code[TW-1];
   endfunction
endpackage

// File: rtl/isu_rotor.sv
module isu_rotor #(
   parameter int NG = 4,
   parameter int GW = 2
) (
   input  logic          clk,
   input  logic          rst,
   output logic [GW-1:0] grp
);
   if ((1 << GW) == NG) begin : g_pow2
      always_ff @(posedge clk) begin
         if (rst) grp <= '0;
         else     grp <= grp + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (rst)                    grp <= '0;
         else if (grp == GW'(NG-1))  grp <= '0;
         else                        grp <= grp + 1'b1;
      end
   end
endmodule

// File: rtl/isu_wave_tbl.sv
module isu_wave_tbl
   import isu_pkg::*;
#(
   parameter int NWT   = 40,
   parameter int AGE_W = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NWT-1:0]       ld_en,
   input  logic [NWT*TW-1:0]    ld_type,
   input  logic [NWT-1:0]       hit,
   output logic [NWT-1:0]       pend,
   output logic [NWT*TW-1:0]    typ,
   output logic [NWT*AGE_W-1:0] age
);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   for (genvar i = 0; i < NWT; i++) begin : g_slot
      logic              p_q;
      logic [TW-1:0]     t_q;
      logic [AGE_W-1:0]  a_q;
      logic              drop;

      assign drop = hit[i] | is_internal(t_q);

      always_ff @(posedge clk) begin
         if (rst) begin
            p_q <= 1'b0;
            t_q <= '0;
            a_q <= '0;
         end else if (p_q) begin
            if (drop)                 p_q <= 1'b0;
            else if (a_q != AGE_MAX)  a_q <= a_q + 1'b1;
         end else if (ld_en[i]) begin
            p_q <= 1'b1;
            t_q <= ld_type[i*TW +: TW];
            a_q <= '0;
         end
      end

      assign pend[i]                = p_q;
      assign typ[i*TW +: TW]        = t_q;
      assign age[i*AGE_W +: AGE_W]  = a_q;
   end
endmodule

// File: rtl/isu_pick.sv
module isu_pick #(
   parameter int NW    = 10,
   parameter int AGE_W = 4,
   parameter int WIDX  = 4
) (
   input  logic [NW-1:0]       cand,
   input  logic [NW*AGE_W-1:0] ages,
   output logic                found,
   output logic [WIDX-1:0]     idx
);
   logic [AGE_W-1:0] best;

   // strict compare keeps the lowest index on equal age
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int w = 0; w < NW; w++) begin
         if (cand[w] && (!found || ages[w*AGE_W +: AGE_W] > best)) begin
            found = 1'b1;
            idx   = WIDX'(w);
            best  = ages[w*AGE_W +: AGE_W];
         end
      end
   end
endmodule

// File: rtl/isu_sched.sv
module isu_sched
   import isu_pkg::*;
#(
   parameter  int NG    = 4,
   parameter  int NW    = 10,
   parameter  int AGE_W = 4,
   localparam int NWT   = NG * NW,
   localparam int WIDX  = $clog2(NW),
   localparam int GW    = $clog2(NG)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NWT-1:0]       ld_en,
   input  logic [NWT*TW-1:0]    ld_type,
   input  logic [NWT-1:0]       dep_rdy,
   input  logic [NCLS-1:0]      port_busy,
   output logic [NCLS-1:0]      iss_vld,
   output logic [NCLS*WIDX-1:0] iss_wave,
   output logic [NCLS*GW-1:0]   iss_grp
);
   if (NG < 2)    begin : g_bad_ng  $error("isu_sched: NG must be at least 2");    end
   if (NW < 2)    begin : g_bad_nw  $error("isu_sched: NW must be at least 2");    end
   if (AGE_W < 1) begin : g_bad_age $error("isu_sched: AGE_W must be at least 1"); end

   logic [GW-1:0]          grp;
   logic [NWT-1:0]         pend;
   logic [NWT-1:0]         hit;
   logic [NWT*TW-1:0]      typ;
   logic [NWT*AGE_W-1:0]   age;
   logic [NW*AGE_W-1:0]    g_age;
   logic [NCLS-1:0][NW-1:0] cand;
   logic [NCLS-1:0]        found;
   logic [NCLS-1:0]        fire;
   logic [WIDX-1:0]        pidx [NCLS];

   isu_rotor #(.NG(NG), .GW(GW)) u_rot (
      .clk (clk),
      .rst (rst),
      .grp (grp)
   );

   isu_wave_tbl #(.NWT(NWT), .AGE_W(AGE_W)) u_tbl (
      .clk     (clk),
      .rst     (rst),
      .ld_en   (ld_en),
      .ld_type (ld_type),
      .hit     (hit),
      .pend    (pend),
      .typ     (typ),
      .age     (age)
   );

   // slice out the active group
   always_comb begin
      for (int w = 0; w < NW; w++) begin
         int base;
         base = int'(grp) * NW + w;
         g_age[w*AGE_W +: AGE_W] = age[base*AGE_W +: AGE_W];
         for (int c = 0; c < NCLS; c++) begin
            cand[c][w] = pend[base] && dep_rdy[base] &&
                         (typ[base*TW +: TW] == TW'(c));
         end
      end
   end

   for (genvar c = 0; c < NCLS; c++) begin : g_port
      isu_pick #(.NW(NW), .AGE_W(AGE_W), .WIDX(WIDX)) u_pick (
         .cand  (cand[c]),
         .ages  (g_age),
         .found (found[c]),
         .idx   (pidx[c])
      );
      assign fire[c] = found[c] & ~port_busy[c];
   end

   always_comb begin
      hit = '0;
      for (int c = 0; c < NCLS; c++) begin
         if (fire[c]) hit[int'(grp) * NW + int'(pidx[c])] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         iss_vld  <= '0;
         iss_wave <= '0;
         iss_grp  <= '0;
      end else begin
         for (int c = 0; c < NCLS; c++) begin
            iss_vld[c]               <= fire[c];
            iss_wave[c*WIDX +: WIDX] <= fire[c] ? pidx[c] : '0;
            iss_grp[c*GW +: GW]      <= fire[c] ? grp : '0;
         end
      end
   end
endmodule

// File: rtl/isu_sched_chk.sv
module isu_sched_chk #(
   parameter int NG   = 4,
   parameter int NW   = 10,
   parameter int WIDX = 4,
   parameter int GW   = 2,
   parameter int NP   = 4
) (
   input logic                clk,
   input logic                rst,
   input logic [NG*NW-1:0]    dep_rdy,
   input logic [NP-1:0]       port_busy,
   input logic [NP-1:0]       iss_vld,
   input logic [NP*WIDX-1:0]  iss_wave,
   input logic [NP*GW-1:0]    iss_grp
);
   logic [GW-1:0]    slot_q;
   logic [GW-1:0]    served_q;
   logic [NG*NW-1:0] rdy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q   <= '0;
         served_q <= '0;
         rdy_q    <= '0;
      end else begin
         slot_q   <= (slot_q == GW'(NG-1)) ? '0 : slot_q + 1'b1;
         served_q <= slot_q;
         rdy_q    <= dep_rdy;
      end
   end

   for (genvar c = 0; c < NP; c++) begin : g_p
      // R1
      grp_rot_chk: assert property (@(posedge clk) disable iff (rst)
         iss_vld[c] |-> iss_grp[c*GW +: GW] == served_q);
      // R2
      wave_rng_chk: assert property (@(posedge clk) disable iff (rst)
         iss_vld[c] |-> int'(iss_wave[c*WIDX +: WIDX]) < NW);
      // R2
      rdy_src_chk: assert property (@(posedge clk) disable iff (rst)
         (iss_vld[c] && int'(iss_wave[c*WIDX +: WIDX]) < NW) |->
            rdy_q[int'(iss_grp[c*GW +: GW]) * NW + int'(iss_wave[c*WIDX +: WIDX])]);
      // R5
      busy_blk_chk: assert property (@(posedge clk) disable iff (rst)
         iss_vld[c] |-> !$past(port_busy[c]));
      // R8
      idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
         !iss_vld[c] |-> (iss_wave[c*WIDX +: WIDX] == '0 && iss_grp[c*GW +: GW] == '0));
      for (genvar d = c + 1; d < NP; d++) begin : g_q
         // R3
         distinct_wave_chk: assert property (@(posedge clk) disable iff (rst)
            (iss_vld[c] && iss_vld[d]) |->
               iss_wave[c*WIDX +: WIDX] != iss_wave[d*WIDX +: WIDX]);
      end
   end
endmodule

bind isu_sched isu_sched_chk #(.NG(NG), .NW(NW), .WIDX(WIDX), .GW(GW), .NP(4)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .dep_rdy   (dep_rdy),
   .port_busy (port_busy),
   .iss_vld   (iss_vld),
   .iss_wave  (iss_wave),
   .iss_grp   (iss_grp)
);

// File: tb/sim_isu_sched.sv
module sim_isu_sched;
   localparam int NG = 4, NW = 10, NWT = 40, NP = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst = 1'b1;
   logic [NWT-1:0]   ld_en = '0;
   logic [NWT*3-1:0] ld_type = '0;
   logic [NWT-1:0]   dep_rdy = '0;
   logic [NP-1:0]    port_busy = '0;
   logic [NP-1:0]    iss_vld;
   logic [NP*4-1:0]  iss_wave;
   logic [NP*2-1:0]  iss_grp;

   isu_sched u0 (.clk(clk), .rst(rst), .ld_en(ld_en), .ld_type(ld_type),
                 .dep_rdy(dep_rdy), .port_busy(port_busy),
                 .iss_vld(iss_vld), .iss_wave(iss_wave), .iss_grp(iss_grp));

   int checks = 0, errors = 0;
   logic done = 1'b0;

   // stimulus staged for the next step
   logic             d_rst = 1'b1;
   logic [NWT-1:0]   d_ld = '0;
   logic [NWT*3-1:0] d_ty = '0;
   logic [NWT-1:0]   d_rdy = '0;
   logic [NP-1:0]    d_busy = '0;

   // reference model
   int m_pend [NWT];
   int m_typ  [NWT];
   int m_age  [NWT];
   int m_rot;
   int e_vld  [NP];
   int e_wave [NP];
   int e_grp  [NP];

   // scenario observations
   int quad_seen, vec_seen, sca_seen, busy_leak, first_vec;

   task automatic model_reset();
      for (int i = 0; i < NWT; i++) begin m_pend[i] = 0; m_typ[i] = 0; m_age[i] = 0; end
      for (int c = 0; c < NP; c++) begin e_vld[c] = 0; e_wave[c] = 0; e_grp[c] = 0; end
      m_rot = 0;
   endtask

   task automatic model_step();
      int issued [NWT];
      for (int i = 0; i < NWT; i++) issued[i] = 0;
      for (int c = 0; c < NP; c++) begin
         int best;
         best = -1;
         for (int w = 0; w < NW; w++) begin
            int i;
            i = m_rot * NW + w;
            if (m_pend[i] != 0 && m_typ[i] == c && d_rdy[i])
               if (best < 0 || m_age[i] > m_age[best]) best = i;
         end
         if (best >= 0 && !d_busy[c]) begin
            e_vld[c] = 1; e_wave[c] = best - m_rot * NW; e_grp[c] = m_rot;
            issued[best] = 1;
         end else begin
            e_vld[c] = 0; e_wave[c] = 0; e_grp[c] = 0;
         end
      end
      for (int i = 0; i < NWT; i++) begin
         if (m_pend[i] != 0) begin
            if (issued[i] != 0 || m_typ[i] >= 4) m_pend[i] = 0;
            else if (m_age[i] < 15) m_age[i]++;
         end else if (d_ld[i]) begin
            m_pend[i] = 1; m_typ[i] = int'(d_ty[i*3 +: 3]); m_age[i] = 0;
         end
      end
      m_rot = (m_rot + 1) % NG;
   endtask

   task automatic compare();
      for (int c = 0; c < NP; c++) begin
         int aw, ag;
         aw = int'(iss_wave[c*4 +: 4]); ag = int'(iss_grp[c*2 +: 2]);
         checks++;
         if (int'(iss_vld[c]) != e_vld[c]) begin
            errors++;
            $display("FAIL R2 port %0d valid: actual %0d expected %0d", c, iss_vld[c], e_vld[c]);
         end else if (e_vld[c] != 0) begin
            checks++;
            if (aw != e_wave[c]) begin
               errors++;
               $display("FAIL R4 port %0d wave: actual %0d expected %0d", c, aw, e_wave[c]);
            end
            checks++;
            if (ag != e_grp[c]) begin
               errors++;
               $display("FAIL R1 port %0d group: actual %0d expected %0d", c, ag, e_grp[c]);
            end
         end else begin
            checks++;
            if (aw != 0 || ag != 0) begin
               errors++;
               $display("FAIL R8 port %0d idle fields: actual %0d/%0d expected 0/0", c, aw, ag);
            end
         end
      end
      if (iss_vld == 4'hF) quad_seen++;
      if (iss_vld[0]) vec_seen++;
      if (iss_vld[1]) sca_seen++;
      if (iss_vld[0] && iss_grp[1:0] == 2'd0 && first_vec < 0) first_vec = int'(iss_wave[3:0]);
   endtask

   task automatic step();
      @(negedge clk);
      compare();
      rst = d_rst; ld_en = d_ld; ld_type = d_ty; dep_rdy = d_rdy; port_busy = d_busy;
      if (d_rst) model_reset(); else model_step();
      d_ld = '0;
   endtask

   task automatic load(input int g, input int w, input int t);
      d_ld[g*NW + w] = 1'b1;
      d_ty[(g*NW + w)*3 +: 3] = 3'(t);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      model_reset();
      quad_seen = 0; vec_seen = 0; sca_seen = 0; busy_leak = 0; first_vec = -1;
      repeat (3) @(posedge clk);
      // R9: reset clears outputs, loads during reset dropped
      load(0, 0, 0); d_rdy = '1;
      step(); step();
      check("R9 valid during reset", int'(iss_vld), 0);
      d_rst = 1'b0; d_rdy = '0;
      // R10: nothing pending, rotation keeps going
      repeat (8) step();
      check("R10 idle valid", int'(iss_vld), 0);

      // R3: quad issue from group 1
      d_rdy = '1;
      load(1, 0, 0); load(1, 1, 1); load(1, 2, 2); load(1, 3, 3);
      repeat (8) step();
      check("R3 quad issue seen", quad_seen, 1);

      // R5: vector port busy holds the candidate
      vec_seen = 0;
      d_busy = 4'b0001;
      load(2, 4, 0);
      repeat (12) step();
      check("R5 no vector while busy", vec_seen, 0);
      d_busy = '0;
      repeat (6) step();
      check("R5 vector after release", vec_seen, 1);

      // R4: older wave 7 beats younger wave 2 in group 0
      d_rdy = '0; first_vec = -1;
      load(0, 7, 0);
      repeat (3) step();
      load(0, 2, 0);
      repeat (2) step();
      d_rdy[7] = 1'b1; d_rdy[2] = 1'b1;
      repeat (10) step();
      check("R4 oldest first", first_vec, 7);

      // R7: second load into pending slot ignored
      d_rdy = '0; sca_seen = 0; vec_seen = 0;
      load(3, 0, 1);
      step();
      load(3, 0, 0);
      step();
      d_rdy = '1;
      repeat (8) step();
      check("R7 scalar kept", sca_seen, 1);
      check("R7 vector reload ignored", vec_seen, 0);

      // R6: internal marker drops, slot reloads with a vector
      vec_seen = 0;
      load(0, 1, 5);
      step();
      step();
      load(0, 1, 0);
      repeat (8) step();
      check("R6 vector after marker", vec_seen, 1);

      // mixed random traffic
      for (int n = 0; n < 4000; n++) begin
         for (int i = 0; i < NWT; i++) begin
            d_ld[i] = ($urandom % 6) == 0;
            d_ty[i*3 +: 3] = 3'($urandom % 6);
            d_rdy[i] = ($urandom % 10) < 7;
         end
         for (int c = 0; c < NP; c++) d_busy[c] = ($urandom % 5) == 0;
         step();
      end
      d_rdy = '0; d_busy = '0;
      repeat (4) step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule